// File: doc/BRIEF.md
# Maskable Interrupt Acceptance Controller

This block decides, once per instruction boundary, whether a simple processor core takes a maskable interrupt, and which one. Every source has a small control register. It holds a pending bit, which the hardware sets and software or an acknowledge clears, and a three-bit level field. One global enable flag and a processor level register gate all sources. In each boundary cycle the block drives a single accept pulse together with the index and level of the winning source.

The core updates the enable flag through one of two paths. A return-from-interrupt update takes part in the acceptance decision of the same boundary. An ordinary flag write (set, clear, pop or load) takes part only from the next boundary on. After an interrupt is taken, the core acknowledges the chosen index, and the block clears that pending bit. Software can clear pending bits but can never set them.

Top module: `irq_accept_ctrl`

## Requirements
- R1: After reset the enable flag is 0, the processor level is 0, every source level is 0, no request is pending and `accept` is low.
- R2: A 1 on `src_req[i]` sets pending bit i at the next clock edge. The bit then stays set until a clear reaches it.
- R3: `ack` with `ack_idx`=i clears pending bit i at the next edge.
- R4: A write with `cfg_we`=1 loads `cfg_lvl` into the level field of source `cfg_sel`. If `cfg_req_bit`=0, the same write clears that source's pending bit. If `cfg_req_bit`=1, the pending bit keeps its value.
- R5: When a request event and a clear (a software clear or an acknowledge) hit the same bit in the same cycle, the bit ends up set.
- R6: `accept` is high only in a cycle with `insn_bnd`=1 and an effective enable of 1, and only when some pending source has a level strictly greater than the processor level. A source at level 0 is never accepted.
- R7: Among eligible sources, the highest level wins, and a tie goes to the lowest index. `win_idx` and `win_lvl` show the winner while `accept` is high and are 0 otherwise.
- R8: An ordinary flag write (`flag_wr_ord`=1) loads `flag_val` into the enable flag at the next edge. A boundary check in the same cycle still uses the old flag.
- R9: A return-from-interrupt write (`flag_wr_ret`=1) uses `flag_val` as the effective enable for a boundary check in the same cycle, and also loads it into the flag. If both write strobes are high, this path wins.
- R10: `ipl_we` loads `ipl_wdata` into the processor level at the next edge. A check in the same cycle uses the old level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| src_req | input | NSRC | Request events, one per source |
| insn_bnd | input | 1 | One-cycle instruction boundary strobe |
| flag_wr_ret | input | 1 | Enable flag update by return-from-interrupt |
| flag_wr_ord | input | 1 | Enable flag update by an ordinary flag instruction |
| flag_val | input | 1 | New enable flag value |
| ipl_we | input | 1 | Processor level write strobe |
| ipl_wdata | input | LVL_W | New processor level |
| cfg_we | input | 1 | Control register write strobe |
| cfg_sel | input | IDX_W | Source addressed by the write |
| cfg_lvl | input | LVL_W | Level written to the addressed source |
| cfg_req_bit | input | 1 | Pending bit value written (0 clears, 1 leaves it unchanged) |
| ack | input | 1 | Core acknowledge strobe |
| ack_idx | input | IDX_W | Source being acknowledged |
| accept | output | 1 | Interrupt accepted at this boundary |
| win_idx | output | IDX_W | Winning source index |
| win_lvl | output | LVL_W | Winning source level |
| ien_o | output | 1 | Stored enable flag |
| ipl_o | output | LVL_W | Stored processor level |
| pend_o | output | NSRC | Pending bits |

## Verification
The assertions check on every cycle the properties that hold at any moment. An accept only comes at a boundary, and the winner is pending and above the processor level. The outputs are zero while nothing is accepted. An event always leaves its bit set, and an acknowledge clears its bit. Writing 1 never sets a bit. An ordinary flag write lands one cycle later, and a return-from-interrupt disable blocks the same boundary. Some behaviour needs a known history, so only the bench scenarios show it: that the winner is the highest level with ties going to the lowest index, that level 0 is excluded, that the comparison is strict, and how the enable and level timing interleaves with acknowledges across several instructions.

// File: rtl/irq_acc_pkg.sv
package irq_acc_pkg;

  // Which path updates the global enable flag this cycle
  typedef enum logic [1:0] {
    FLAG_HOLD = 2'd0,
    FLAG_ORD  = 2'd1,
    FLAG_RET  = 2'd2
  } flag_path_e;

  // Return-from-interrupt takes precedence over an ordinary write
  function automatic flag_path_e flag_path(input logic ret, input logic ord);
    if (ret)      return FLAG_RET;
    else if (ord) return FLAG_ORD;
    else          return FLAG_HOLD;
  endfunction

endpackage

// File: rtl/irq_src_cell.sv
module irq_src_cell #(
  parameter int LVL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt,
  input  logic             clr,
  input  logic             lvl_we,
  input  logic [LVL_W-1:0] lvl_wdata,
  output logic             pend_o,
  output logic [LVL_W-1:0] lvl_o
);

  logic             pend_q, pend_d;
  logic [LVL_W-1:0] lvl_q, lvl_d;

  // An event wins over any clear so no request is lost
  always_comb begin
    pend_d = (pend_q & ~clr) | evt;
    lvl_d  = lvl_q;
    if (lvl_we) lvl_d = lvl_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      lvl_q  <= '0;
    end else begin
      pend_q <= pend_d;
      if (lvl_we) lvl_q <= lvl_d;
    end
  end

  assign pend_o = pend_q;
  assign lvl_o  = lvl_q;

endmodule

// File: rtl/irq_flag_unit.sv
module irq_flag_unit
  import irq_acc_pkg::*;
#(
  parameter int LVL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_ret,
  input  logic             wr_ord,
  input  logic             val,
  input  logic             ipl_we,
  input  logic [LVL_W-1:0] ipl_wdata,
  output logic             ien_q_o,
  output logic             ien_eff_o,
  output logic [LVL_W-1:0] ipl_q_o
);

  flag_path_e       path;
  logic             ien_q, ien_d, ien_en;
  logic [LVL_W-1:0] ipl_q, ipl_d;

  always_comb begin
    path   = flag_path(wr_ret, wr_ord);
    ien_en = (path != FLAG_HOLD);
    ien_d  = ien_en ? val : ien_q;
    ipl_d  = ipl_we ? ipl_wdata : ipl_q;
    // Only the return path reaches the check of the current boundary
    ien_eff_o = (path == FLAG_RET) ? val : ien_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q <= 1'b0;
      ipl_q <= '0;
    end else begin
      if (ien_en) ien_q <= ien_d;
      if (ipl_we) ipl_q <= ipl_d;
    end
  end

  assign ien_q_o = ien_q;
  assign ipl_q_o = ipl_q;

endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int NSRC  = 8,
  parameter int LVL_W = 3,
  localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic [NSRC-1:0]       pend,
  input  logic [NSRC*LVL_W-1:0] lvls,
  input  logic [LVL_W-1:0]      ipl,
  output logic                  any_o,
  output logic [IDX_W-1:0]      idx_o,
  output logic [LVL_W-1:0]      lvl_o
);

  logic [NSRC-1:0] elig;

  genvar gi;
  generate
    for (gi = 0; gi < NSRC; gi++) begin : g_elig
      // Strict compare also removes level 0
      assign elig[gi] = pend[gi] && (lvls[gi*LVL_W +: LVL_W] > ipl);
    end
  endgenerate

  always_comb begin
    idx_o = '0;
    lvl_o = '0;
    for (int i = 0; i < NSRC; i++) begin
      // Strictly greater keeps the lowest index on a tie
      if (elig[i] && (lvls[i*LVL_W +: LVL_W] > lvl_o)) begin
        idx_o = IDX_W'(i);
        lvl_o = lvls[i*LVL_W +: LVL_W];
      end
    end
    any_o = |elig;
  end

endmodule

// File: rtl/irq_accept_ctrl.sv
module irq_accept_ctrl #(
  parameter int NSRC  = 8,
  parameter int LVL_W = 3,
  localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  src_req,
  input  logic             insn_bnd,
  input  logic             flag_wr_ret,
  input  logic             flag_wr_ord,
  input  logic             flag_val,
  input  logic             ipl_we,
  input  logic [LVL_W-1:0] ipl_wdata,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_sel,
  input  logic [LVL_W-1:0] cfg_lvl,
  input  logic             cfg_req_bit,
  input  logic             ack,
  input  logic [IDX_W-1:0] ack_idx,
  output logic             accept,
  output logic [IDX_W-1:0] win_idx,
  output logic [LVL_W-1:0] win_lvl,
  output logic             ien_o,
  output logic [LVL_W-1:0] ipl_o,
  output logic [NSRC-1:0]  pend_o
);

  // Reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [NSRC-1:0]       clr;
  logic [NSRC-1:0]       lvl_we;
  logic [NSRC*LVL_W-1:0] lvls;
  logic                  ien_eff;
  logic                  any_elig;
  logic [IDX_W-1:0]      pick_idx;
  logic [LVL_W-1:0]      pick_lvl;

  genvar gi;
  generate
    for (gi = 0; gi < NSRC; gi++) begin : g_src
      assign lvl_we[gi] = cfg_we && (cfg_sel == IDX_W'(gi));
      assign clr[gi]    = (lvl_we[gi] && !cfg_req_bit) ||
                          (ack && (ack_idx == IDX_W'(gi)));

      irq_src_cell #(.LVL_W(LVL_W)) u_cell (
        .clk       (clk),
        .rst_n     (rst_int_n),
        .evt       (src_req[gi]),
        .clr       (clr[gi]),
        .lvl_we    (lvl_we[gi]),
        .lvl_wdata (cfg_lvl),
        .pend_o    (pend_o[gi]),
        .lvl_o     (lvls[gi*LVL_W +: LVL_W])
      );
    end
  endgenerate

  irq_flag_unit #(.LVL_W(LVL_W)) u_flag (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .wr_ret    (flag_wr_ret),
    .wr_ord    (flag_wr_ord),
    .val       (flag_val),
    .ipl_we    (ipl_we),
    .ipl_wdata (ipl_wdata),
    .ien_q_o   (ien_o),
    .ien_eff_o (ien_eff),
    .ipl_q_o   (ipl_o)
  );

  irq_pick #(.NSRC(NSRC), .LVL_W(LVL_W)) u_pick (
    .pend  (pend_o),
    .lvls  (lvls),
    .ipl   (ipl_o),
    .any_o (any_elig),
    .idx_o (pick_idx),
    .lvl_o (pick_lvl)
  );

  always_comb begin
    accept  = insn_bnd && ien_eff && any_elig;
    win_idx = accept ? pick_idx : '0;
    win_lvl = accept ? pick_lvl : '0;
  end

endmodule

// File: rtl/irq_accept_chk.sv
module irq_accept_chk #(
  parameter int NSRC  = 8,
  parameter int LVL_W = 3,
  localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NSRC-1:0]  src_req,
  input logic             insn_bnd,
  input logic             flag_wr_ret,
  input logic             flag_wr_ord,
  input logic             flag_val,
  input logic             cfg_we,
  input logic [IDX_W-1:0] cfg_sel,
  input logic             cfg_req_bit,
  input logic             ack,
  input logic [IDX_W-1:0] ack_idx,
  input logic             accept,
  input logic [IDX_W-1:0] win_idx,
  input logic [LVL_W-1:0] win_lvl,
  input logic             ien_o,
  input logic [LVL_W-1:0] ipl_o,
  input logic [NSRC-1:0]  pend_o
);

  assert_acc_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (insn_bnd && (win_lvl > ipl_o) && (win_lvl != '0)));

  assert_win_pend_R7: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> pend_o[win_idx]);

  assert_idle_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |-> ((win_idx == '0) && (win_lvl == '0)));

  assert_evt_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (src_req != '0) |=> ((pend_o & $past(src_req)) == $past(src_req)));

  assert_ack_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !src_req[ack_idx]) |=> !pend_o[$past(ack_idx)]);

  assert_one_noset_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_req_bit && !pend_o[cfg_sel] && !src_req[cfg_sel]) |=>
      !pend_o[$past(cfg_sel)]);

  assert_ord_late_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_wr_ord && !flag_wr_ret) |=> (ien_o == $past(flag_val)));

  assert_ret_now_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_bnd && flag_wr_ret && !flag_val) |-> !accept);

endmodule

bind irq_accept_ctrl irq_accept_chk #(.NSRC(NSRC), .LVL_W(LVL_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .src_req     (src_req),
  .insn_bnd    (insn_bnd),
  .flag_wr_ret (flag_wr_ret),
  .flag_wr_ord (flag_wr_ord),
  .flag_val    (flag_val),
  .cfg_we      (cfg_we),
  .cfg_sel     (cfg_sel),
  .cfg_req_bit (cfg_req_bit),
  .ack         (ack),
  .ack_idx     (ack_idx),
  .accept      (accept),
  .win_idx     (win_idx),
  .win_lvl     (win_lvl),
  .ien_o       (ien_o),
  .ipl_o       (ipl_o),
  .pend_o      (pend_o)
);

// File: tb/tb_irq_accept_ctrl.sv
module tb_irq_accept_ctrl;

  localparam int NSRC  = 8;
  localparam int LVL_W = 3;
  localparam int IDX_W = 3;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [NSRC-1:0]  src_req;
  logic             insn_bnd, flag_wr_ret, flag_wr_ord, flag_val;
  logic             ipl_we;
  logic [LVL_W-1:0] ipl_wdata;
  logic             cfg_we;
  logic [IDX_W-1:0] cfg_sel;
  logic [LVL_W-1:0] cfg_lvl;
  logic             cfg_req_bit;
  logic             ack;
  logic [IDX_W-1:0] ack_idx;
  logic             accept;
  logic [IDX_W-1:0] win_idx;
  logic [LVL_W-1:0] win_lvl;
  logic             ien_o;
  logic [LVL_W-1:0] ipl_o;
  logic [NSRC-1:0]  pend_o;

  always #2.5 clk = ~clk;

  irq_accept_ctrl #(.NSRC(NSRC), .LVL_W(LVL_W)) dut (.*);

  typedef struct {
    string tag;
    logic  acc;
    int    idx;
    int    lvl;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0;
  int   n_bad = 0;

  // Bench-side model of architectural state
  logic [NSRC-1:0] m_pend;
  int              m_lvl[NSRC];
  logic            m_ien;
  int              m_ipl;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic idle();
    src_req = '0; insn_bnd = 0; flag_wr_ret = 0; flag_wr_ord = 0; flag_val = 0;
    ipl_we = 0; ipl_wdata = '0; cfg_we = 0; cfg_sel = '0; cfg_lvl = '0;
    cfg_req_bit = 0; ack = 0; ack_idx = '0;
  endtask

  // Driver: inputs are already set; push expectation, update model, advance
  task automatic tick(input string tag);
    exp_t e;
    logic eff;
    logic [NSRC-1:0] clr;
    eff = flag_wr_ret ? flag_val : m_ien;
    e.tag = tag; e.acc = 0; e.idx = 0; e.lvl = 0;
    if (insn_bnd && eff) begin
      for (int i = 0; i < NSRC; i++)
        if (m_pend[i] && m_lvl[i] > m_ipl && m_lvl[i] > e.lvl) begin
          e.acc = 1; e.idx = i; e.lvl = m_lvl[i];
        end
    end
    if (insn_bnd) q.push_back(e);
    clr = '0;
    if (cfg_we && !cfg_req_bit) clr[cfg_sel] = 1'b1;
    if (ack) clr[ack_idx] = 1'b1;
    m_pend = (m_pend & ~clr) | src_req;
    if (cfg_we) m_lvl[cfg_sel] = int'(cfg_lvl);
    if (flag_wr_ret || flag_wr_ord) m_ien = flag_val;
    if (ipl_we) m_ipl = int'(ipl_wdata);
    @(posedge clk); #1;
    idle();
  endtask

  task automatic cfgw(input int sel, input int lvl, input logic bitv, input string tag);
    cfg_we = 1; cfg_sel = IDX_W'(sel); cfg_lvl = LVL_W'(lvl); cfg_req_bit = bitv;
    tick(tag);
  endtask

  // Monitor: pop and compare at each boundary, away from the clock edge
  always @(negedge clk) begin
    if (rst_n && insn_bnd) begin
      n_chk++;
      if (q.size() == 0) begin
        n_bad++;
        $display("FAIL scoreboard empty: accept=%0b", accept);
      end else begin
        exp_t e;
        e = q.pop_front();
        if (accept !== e.acc || int'(win_idx) != e.idx || int'(win_lvl) != e.lvl) begin
          n_bad++;
          $display("FAIL %s: got acc=%0b idx=%0d lvl=%0d expected acc=%0b idx=%0d lvl=%0d",
                   e.tag, accept, win_idx, win_lvl, e.acc, e.idx, e.lvl);
        end
      end
    end
  end

  initial begin
    #200000;
    n_bad++;
    n_chk++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    idle();
    m_pend = '0; m_ien = 0; m_ipl = 0;
    for (int i = 0; i < NSRC; i++) m_lvl[i] = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (3) @(posedge clk);
    #1;

    chk("R1 ien", 32'(ien_o), 0);
    chk("R1 ipl", 32'(ipl_o), 0);
    chk("R1 pend", 32'(pend_o), 0);
    chk("R1 accept", 32'(accept), 0);
    insn_bnd = 1; tick("R1 boundary idle");

    // Levels; writing 1 to the pending bit must not set it
    cfgw(2, 3, 1, "R4"); cfgw(5, 5, 1, "R4"); cfgw(6, 5, 1, "R4"); cfgw(1, 0, 1, "R4");
    chk("R4 write one no set", 32'(pend_o), 0);

    src_req = 8'h66; tick("R2");
    chk("R2 pend latched", 32'(pend_o), 32'h66);

    insn_bnd = 1; tick("R6 enable low");

    flag_wr_ord = 1; flag_val = 1; insn_bnd = 1; tick("R8 old flag used");
    chk("R8 flag stored", 32'(ien_o), 1);

    insn_bnd = 1; ack = 1; ack_idx = 3'd5; tick("R7 tie lowest index");
    chk("R3 ack clears", 32'(pend_o), 32'h46);

    ipl_we = 1; ipl_wdata = 3'd5; insn_bnd = 1; tick("R10 old level used");
    chk("R10 level stored", 32'(ipl_o), 5);
    insn_bnd = 1; tick("R6 strict compare");
    ipl_we = 1; ipl_wdata = 3'd4; tick("R10");
    insn_bnd = 1; tick("R6 above level");

    flag_wr_ord = 1; flag_val = 0; tick("R8");
    chk("R8 flag cleared", 32'(ien_o), 0);
    flag_wr_ret = 1; flag_val = 1; insn_bnd = 1; ack = 1; ack_idx = 3'd6;
    tick("R9 return enables now");
    chk("R9 flag stored", 32'(ien_o), 1);
    chk("R3 pend after ack", 32'(pend_o), 32'h06);

    ipl_we = 1; ipl_wdata = 3'd0; tick("R10");
    flag_wr_ret = 1; flag_val = 0; insn_bnd = 1; tick("R9 return disables now");
    chk("R9 flag cleared", 32'(ien_o), 0);
    flag_wr_ret = 1; flag_wr_ord = 1; flag_val = 1; insn_bnd = 1; ack = 1; ack_idx = 3'd2;
    tick("R9 return wins over ordinary");
    chk("R3 pend level0 left", 32'(pend_o), 32'h02);
    insn_bnd = 1; tick("R6 level zero never");

    cfgw(1, 0, 0, "R4");
    chk("R4 zero clears", 32'(pend_o), 0);

    src_req = 8'h10; cfg_we = 1; cfg_sel = 3'd4; cfg_lvl = 3'd2; cfg_req_bit = 0;
    tick("R5 event over clear");
    chk("R5 event kept", 32'(pend_o), 32'h10);
    src_req = 8'h10; ack = 1; ack_idx = 3'd4; insn_bnd = 1; tick("R5 ack and event");
    chk("R5 event over ack", 32'(pend_o), 32'h10);

    cfgw(0, 7, 1, "R4"); cfgw(7, 7, 1, "R4");
    src_req = 8'h81; tick("R2");
    insn_bnd = 1; tick("R7 highest level tie");
    chk("R2 pend held", 32'(pend_o), 32'h91);

    @(negedge clk);
    chk("scoreboard drained", 32'(q.size()), 0);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule